// File: doc/BRIEF.md
# Serial Byte Transmitter with Line-Driver Enable

This block turns one parallel byte into an asynchronous serial frame: a low start bit, eight data bits with the least significant bit first, and a high stop bit. It runs from a clock at eight times the bit rate, so every bit is held on the line for eight clock cycles. A shift-enable pulse fires once every eighth cycle and steps a loadable shift register. The block does not divide the clock.

Besides the serial line, the block drives an enable for an external line-driver transceiver. The enable is high only while a frame is on the wire. A busy flag tells the requester that no new byte can be taken. A request that arrives during the final cycle of a stop bit is accepted at once, so frames can follow each other with no idle time between them.

Top module: `uart_tx_de`

## Requirements
- R1: A frame on `tx` is one start bit at 0, then data bits 0 to 7 with bit 0 first, then one stop bit at 1. The data is the value on `tx_data` at the accepting clock edge.
- R2: Each bit of a frame stays on `tx` for exactly OVS clock cycles (8 by default). A frame lasts 10*OVS cycles.
- R3: While no frame is in progress, `tx` is 1, `tx_e` is 0 and `busy` is 0.
- R4: A request is accepted on an edge where `send` is 1 and `busy` is 0. From the next cycle, `tx` carries the start bit. `tx_e` and `busy` are 1 from the first start-bit cycle through the last stop-bit cycle.
- R5: While `busy` is 1, a request on any cycle other than the final stop-bit cycle is ignored. Changes on `tx_data` during a frame do not alter the bits sent.
- R6: If `send` is 1 during the final stop-bit cycle, the next frame's start bit follows on the next cycle. In that case `tx_e` and `busy` stay at 1 without a gap.
- R7: A synchronous reset, `rst` at 1, aborts any frame and forces `tx` to 1, `tx_e` to 0 and `busy` to 0 after the edge. A request during reset is ignored.
- R8: A receiver that detects the falling edge of the start bit and then samples the middle of each bit recovers every transmitted byte intact, with a valid start bit and a valid stop bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at OVS times the bit rate |
| rst | input | 1 | Synchronous reset, active high |
| tx_data | input | DATA_W (8) | Byte to transmit, captured on the accepting edge |
| send | input | 1 | Transmit request |
| tx | output | 1 | Serial line output, idle high |
| tx_e | output | 1 | Line-driver enable, high during a frame |
| busy | output | 1 | Frame in progress |

## Verification
The bench builds the block with its default parameters: an 8-bit byte and an oversampling ratio of 8. This gives 80-cycle frames, which are short enough to compare `tx`, `tx_e` and `busy` against an expected frame on every single cycle. With these values the bench can reach:
- chained frames at the exact stop-bit boundary;
- requests held high through a whole frame, with data that keeps changing;
- a reset in the middle of a frame.

A mid-bit sampling receiver model in the bench reads the looped-back line and confirms each byte.

// File: rtl/utx_pkg.sv
package utx_pkg;

    localparam int unsigned DEF_DATA_W = 8;
    localparam int unsigned DEF_OVS    = 8;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_SEND = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic accept;
        logic shift;
        logic frame_end;
    } tx_ctl_t;

    function automatic int unsigned width_of(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/utx_baud_phase.sv
module utx_baud_phase #(
    parameter int unsigned OVS = utx_pkg::DEF_OVS
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              run,
    input  logic                              restart,
    output logic [utx_pkg::width_of(OVS)-1:0] phase,
    output logic                              tick
);
    localparam int unsigned PH_W = utx_pkg::width_of(OVS);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(OVS - 1);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            phase <= '0;
        end else if (run) begin
            phase <= (phase == PH_LAST) ? '0 : phase + 1'b1;
        end else begin
            phase <= '0;
        end
    end

    assign tick = run && (phase == PH_LAST);
endmodule

// File: rtl/utx_bit_seq.sv
module utx_bit_seq #(
    parameter int unsigned FRAME_BITS = utx_pkg::DEF_DATA_W + 2
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic tick,
    output logic active,
    output logic last_bit
);
    import utx_pkg::*;

    localparam int unsigned CNT_W = width_of(FRAME_BITS);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_BITS - 1);

    seq_state_e       state;
    logic [CNT_W-1:0] bit_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SEQ_IDLE;
            bit_idx <= '0;
        end else if (start) begin
            state   <= SEQ_SEND;
            bit_idx <= '0;
        end else if (state == SEQ_SEND && tick) begin
            if (bit_idx == CNT_LAST) begin
                state   <= SEQ_IDLE;
                bit_idx <= '0;
            end else begin
                bit_idx <= bit_idx + 1'b1;
            end
        end
    end

    assign active   = (state == SEQ_SEND);
    assign last_bit = (bit_idx == CNT_LAST);
endmodule

// File: rtl/utx_shifter.sv
module utx_shifter #(
    parameter int unsigned DATA_W = utx_pkg::DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              shift,
    input  logic [DATA_W-1:0] din,
    output logic              sdo
);
    localparam int unsigned FRAME_BITS = DATA_W + 2;

    logic [FRAME_BITS-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr <= '1;
        end else if (load) begin
            sr <= {1'b1, din, 1'b0};
        end else if (shift) begin
            sr <= {1'b1, sr[FRAME_BITS-1:1]};
        end
    end

    assign sdo = sr[0];
endmodule

// File: rtl/uart_tx_de.sv
module uart_tx_de #(
    parameter int unsigned DATA_W = utx_pkg::DEF_DATA_W,
    parameter int unsigned OVS    = utx_pkg::DEF_OVS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              send,
    output logic              tx,
    output logic              tx_e,
    output logic              busy
);
    import utx_pkg::*;

    localparam int unsigned FRAME_BITS = DATA_W + 2;
    localparam int unsigned PH_W       = width_of(OVS);

    tx_ctl_t         ctl;
    logic            active;
    logic            last_bit;
    logic            tick;
    logic [PH_W-1:0] phase;

    // Take a new byte when idle, or on the final cycle of a stop bit.
    assign ctl.frame_end = active && last_bit && tick;
    assign ctl.accept    = send && (!active || ctl.frame_end);
    assign ctl.shift     = tick;

    utx_baud_phase #(.OVS(OVS)) u_phase (
        .clk     (clk),
        .rst     (rst),
        .run     (active),
        .restart (ctl.accept),
        .phase   (phase),
        .tick    (tick)
    );

    utx_bit_seq #(.FRAME_BITS(FRAME_BITS)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (ctl.accept),
        .tick     (tick),
        .active   (active),
        .last_bit (last_bit)
    );

    utx_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk   (clk),
        .rst   (rst),
        .load  (ctl.accept),
        .shift (ctl.shift),
        .din   (tx_data),
        .sdo   (tx)
    );

    assign tx_e = active;
    assign busy = active;
endmodule

// File: rtl/utx_checker.sv
module utx_checker #(
    parameter int unsigned OVS        = 8,
    parameter int unsigned FRAME_BITS = 10,
    parameter int unsigned PH_W       = 3
) (
    input logic            clk,
    input logic            rst,
    input logic            send,
    input logic            tx,
    input logic            tx_e,
    input logic            busy,
    input logic [PH_W-1:0] phase
);
    localparam int unsigned FRAME_CYC = FRAME_BITS * OVS;

    int unsigned run_len;

    always_ff @(posedge clk) begin
        if (rst || !tx_e) run_len <= 0;
        else              run_len <= run_len + 1;
    end

    // R3: line idles high whenever the driver is off
    a_r3_idle_high: assert property (@(posedge clk) disable iff (rst)
        !tx_e |-> tx);

    // R4: the first enabled cycle carries the start bit
    a_r4_start_low: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_e) |-> !tx);

    // R4: a frame only begins after a request
    a_r4_accept_from_send: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(send));

    // R2: the line changes only at a bit boundary
    a_r2_bit_stable: assert property (@(posedge clk) disable iff (rst)
        (tx_e && phase != '0) |-> $stable(tx));

    // R6: an enable burst covers a whole number of frames
    a_r6_whole_frames: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_e) |-> (run_len % FRAME_CYC == 0));

    // R7: the cycle after reset is idle
    a_r7_reset_idle: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (tx && !tx_e && !busy));
endmodule

bind uart_tx_de utx_checker #(
    .OVS        (OVS),
    .FRAME_BITS (FRAME_BITS),
    .PH_W       (PH_W)
) u_chk (
    .clk   (clk),
    .rst   (rst),
    .send  (send),
    .tx    (tx),
    .tx_e  (tx_e),
    .busy  (busy),
    .phase (phase)
);

// File: tb/sim_uart_tx_de.sv
`timescale 1ns/1ps
module sim_uart_tx_de;
    localparam int DW  = 8;
    localparam int OVS = 8;
    localparam int FB  = DW + 2;
    localparam int FC  = FB * OVS;
    localparam int NV  = 8;

    typedef struct packed {
        logic [7:0] d;
        logic [9:0] f;
    } vec_t;

    // byte and expected line bits (bit 0 leaves first)
    localparam vec_t VEC [NV] = '{
        '{d: 8'h3E, f: 10'b1001111100},
        '{d: 8'hA5, f: 10'b1101001010},
        '{d: 8'h00, f: 10'b1000000000},
        '{d: 8'hFF, f: 10'b1111111110},
        '{d: 8'h01, f: 10'b1000000010},
        '{d: 8'h80, f: 10'b1100000000},
        '{d: 8'h55, f: 10'b1010101010},
        '{d: 8'hC3, f: 10'b1110000110}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [DW-1:0] tx_data = '0;
    logic          send = 1'b0;
    logic          tx, tx_e, busy;

    int n_cmp = 0;
    int n_bad = 0;

    logic       rx_en = 1'b1;
    int         rx_cnt = 0;
    logic [7:0] rx_buf [16];
    logic       rx_ok  [16];
    logic [7:0] rx_b;
    logic       rx_st, rx_sp;

    always #5 clk = ~clk;

    uart_tx_de #(.DATA_W(DW), .OVS(OVS)) u0 (
        .clk     (clk),
        .rst     (rst),
        .tx_data (tx_data),
        .send    (send),
        .tx      (tx),
        .tx_e    (tx_e),
        .busy    (busy)
    );

    task automatic chk(input logic got, input logic exp, input string req, input string what);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, got, exp, $time);
        end
    endtask

    task automatic chk_idle(input string req);
        chk(tx,   1'b1, req, "tx idle");
        chk(tx_e, 1'b0, req, "tx_e idle");
        chk(busy, 1'b0, req, "busy idle");
    endtask

    // Checks one frame cycle by cycle. The first negedge is start-bit cycle 0.
    task automatic run_frame(input logic [7:0] d, input logic [9:0] f,
                             input bit hold, input bit chain, input logic [7:0] nd);
        for (int k = 0; k < FC; k++) begin
            @(negedge clk);
            chk(tx,   f[k/OVS], "R1 R2", "tx bit");
            chk(tx_e, 1'b1,     "R4",    "tx_e in frame");
            chk(busy, 1'b1,     "R4",    "busy in frame");
            if (k == FC - 1) begin
                // R6: a request in the final stop-bit cycle chains the next frame
                if (chain) begin tx_data = nd; send = 1'b1; end
                else       begin send = 1'b0; end
            end else if (hold) begin
                // R5: requests and data changes while busy are ignored
                send    = 1'b1;
                tx_data = ~d;
            end else begin
                send = 1'b0;
            end
        end
    endtask

    // Loopback receiver: detects the start edge, then samples the middle of each bit.
    initial begin : rx_model
        forever begin
            @(negedge clk);
            if (!rst && tx === 1'b0) begin
                repeat (OVS/2) @(negedge clk);
                rx_st = tx;
                for (int j = 0; j < 8; j++) begin
                    repeat (OVS) @(negedge clk);
                    rx_b[j] = tx;
                end
                repeat (OVS) @(negedge clk);
                rx_sp = tx;
                if (rx_en && rx_cnt < 16) begin
                    rx_buf[rx_cnt] = rx_b;
                    rx_ok[rx_cnt]  = (rx_st == 1'b0) && (rx_sp == 1'b1);
                    rx_cnt++;
                end
            end
        end
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        // R7: outputs during and after reset
        repeat (3) @(negedge clk);
        chk_idle("R7");
        rst = 1'b0;
        repeat (4) begin
            @(negedge clk);
            chk_idle("R3");
        end

        // Vector walk: even entries start from idle and chain into the next one.
        // Odd entries hold send high and scramble the data during the frame.
        for (int i = 0; i < NV; i++) begin
            if (i % 2 == 0) begin
                @(negedge clk);
                tx_data = VEC[i].d;
                send    = 1'b1;
            end
            run_frame(VEC[i].d, VEC[i].f, (i % 2 == 1), (i % 2 == 0),
                      (i + 1 < NV) ? VEC[i+1].d : 8'h00);
            if (i % 2 == 1) begin
                for (int g = 0; g < 6; g++) begin
                    @(negedge clk);
                    chk_idle("R3 R5");
                end
            end
        end

        // R8: loopback check of the received bytes
        repeat (20) @(negedge clk);
        n_cmp++;
        if (rx_cnt != NV) begin
            n_bad++;
            $display("FAIL R8 byte count: actual %0d expected %0d", rx_cnt, NV);
        end
        for (int i = 0; i < NV && i < rx_cnt; i++) begin
            n_cmp++;
            if (rx_buf[i] !== VEC[i].d || rx_ok[i] !== 1'b1) begin
                n_bad++;
                $display("FAIL R8 byte %0d: actual %h framing %b expected %h framing 1",
                         i, rx_buf[i], rx_ok[i], VEC[i].d);
            end
        end
        rx_en = 1'b0;

        // R7: reset in the middle of a frame, with a request held during reset
        @(negedge clk);
        tx_data = 8'h5A;
        send    = 1'b1;
        @(negedge clk);
        send = 1'b0;
        repeat (30) @(negedge clk);
        chk(tx_e, 1'b1, "R7", "tx_e before abort");
        rst  = 1'b1;
        send = 1'b1;
        @(negedge clk);
        chk_idle("R7");
        @(negedge clk);
        chk_idle("R7");
        rst  = 1'b0;
        send = 1'b0;
        repeat (12) begin
            @(negedge clk);
            chk_idle("R7");
        end

        // R1 R4: a clean frame after the abort
        @(negedge clk);
        tx_data = 8'h96;
        send    = 1'b1;
        run_frame(8'h96, {1'b1, 8'h96, 1'b0}, 1'b0, 1'b0, 8'h00);
        @(negedge clk);
        chk_idle("R3");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule